// File: doc/BRIEF.md
# Access Fault Tracking and Reporting Unit

This unit sits between an in-order pipeline and its bus interface and decides when a bus error turns into an access-error exception. It tracks errors from three sources: instruction prefetches, operand reads and buffered operand writes. When one of them becomes an exception, it produces a 4-bit fault status code, an 8-bit vector number and the program counter to report.

Prefetched words carry their error flag in a small queue. An error in that queue surfaces only when an issued instruction consumes the faulted word. A flow-change flush throws the queued words away, and any error they held goes with them. Operand read errors abort the running instruction at once. Errors on buffered writes come back after the store has retired, so they are reported against whatever instruction is current at that time. A NOP holds the pipeline until the write buffer is empty, so any pending write error is reported on the NOP.

Once raised, the request and its outputs stay frozen until software-side exception logic acknowledges it.

Top module: `acc_fault_unit`

## Requirements
- R1: While `exc_req_o` is high, `exc_fs_o` is one of 4'b0100 (fetch), 4'b1000 (write), 4'b1001 (write to protected space) or 4'b1100 (read), and `exc_vec_o` is 8'd2.
- R2: A prefetch word with its error flag set raises no request when it arrives. The request rises in the cycle after an issue (`issue_i`) whose `issue_words_i` oldest queued words include a faulted one. It carries FS 4'b0100 and reports `issue_pc_i` of that issue. Consumed words leave the queue, and later issues see the remaining words in order.
- R3: `flush_i` empties the prefetch queue, so an error held there never raises a request.
- R4: `kill_o` is high, in the same cycle, on an issue that consumes a faulted word and on a read response with `rd_err_i` set. It is low otherwise.
- R5: A read response with `rd_err_i` set raises a request in the next cycle with FS 4'b1100. It reports the PC of the most recent issue before that cycle.
- R6: A write completion with `wr_err_i` set, while the 4-entry write buffer is non-empty, raises a request in the next cycle. The FS is 4'b1001 when `wr_prot_i` is high and 4'b1000 otherwise. `exc_pc_o` is the PC of the most recent issue before that cycle, and `exc_store_pc_o` is the `wr_pc_i` tag of the oldest buffered store.
- R7: After an issue with `nop_i` high, `stall_o` is high from the next cycle for as long as the write buffer holds entries. A write error that occurs during this stall reports the NOP's PC.
- R8: When events arrive in the same cycle, a write error takes precedence over a read error, and a read error takes precedence over a fetch error.
- R9: While the request is high and `exc_ack_i` is low, the request, FS, vector and PCs hold their values, and new fault events are dropped. The request is low in the cycle after `exc_ack_i`.
- R10: `stall_o` is high while the write buffer holds 4 entries.
- R11: After reset, `exc_req_o`, `kill_o` and `stall_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pf_valid_i | input | 1 | Prefetch word arrives |
| pf_err_i | input | 1 | Bus error on that prefetch |
| flush_i | input | 1 | Flow change; discard prefetch queue |
| issue_i | input | 1 | Instruction issue |
| issue_words_i | input | 2 | Words consumed by the issue (1..3) |
| issue_pc_i | input | 32 | PC of the issued instruction |
| nop_i | input | 1 | Issued instruction is a NOP |
| rd_resp_i | input | 1 | Operand read response |
| rd_err_i | input | 1 | Read response is an error |
| wr_push_i | input | 1 | Store enters write buffer |
| wr_pc_i | input | 32 | PC tag of the store |
| wr_done_i | input | 1 | Oldest buffered write completed |
| wr_err_i | input | 1 | Completion is an error |
| wr_prot_i | input | 1 | Error is a protection violation |
| exc_ack_i | input | 1 | Exception request accepted |
| exc_req_o | output | 1 | Access-error exception request |
| exc_fs_o | output | 4 | Fault status code |
| exc_vec_o | output | 8 | Vector number |
| exc_pc_o | output | 32 | PC to report |
| exc_store_pc_o | output | 32 | PC tag of the faulting store (write faults) |
| kill_o | output | 1 | Block register writes of current instruction |
| stall_o | output | 1 | Pipeline stall |

## Verification
`kill_o` is combinational, so the bench samples it one nanosecond after driving the inputs and before the clock edge. Requests, codes and PCs are registered, so they are due one cycle after the triggering event and are sampled at the following falling edge. `stall_o` is computed from registered state: it changes one cycle after the push, issue or completion that alters the buffer or NOP state, and it is sampled at the falling edge after that edge. The fetch sweep covers every error pattern over three queued words against every issue width, including the follow-up issue of the leftover words.

// File: rtl/acc_fault_pkg.sv
`timescale 1ns/1ps
package acc_fault_pkg;
  typedef enum logic [3:0] {
    FS_FETCH = 4'b0100,
    FS_WRITE = 4'b1000,
    FS_WPROT = 4'b1001,
    FS_READ  = 4'b1100
  } fs_e;
  localparam logic [7:0] ACC_VEC = 8'd2;
endpackage

// File: rtl/pf_err_track.sv
`timescale 1ns/1ps
module pf_err_track #(
  parameter int DEPTH  = 4,
  parameter int TAKE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              err_i,
  input  logic              flush_i,
  input  logic              pop_i,
  input  logic [TAKE_W-1:0] pop_n_i,
  output logic              hit_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] err_q, err_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // slots at or above cnt_q are always zero
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (i < int'(pop_n_i)) hit_o = hit_o | err_q[i];
  end

  always_comb begin
    err_d = err_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      err_d = '0;
      cnt_d = '0;
    end else if (pop_i) begin
      err_d = err_q >> pop_n_i;
      cnt_d = cnt_q - CNT_W'(pop_n_i);
    end
    if (push_i && cnt_d < CNT_W'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++)
        if (CNT_W'(i) == cnt_d) err_d[i] = err_i;
      cnt_d = cnt_d + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
      cnt_q <= '0;
    end else begin
      err_q <= err_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wr_buf_track.sv
`timescale 1ns/1ps
module wr_buf_track #(
  parameter int DEPTH = 4,
  parameter int PC_W  = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            done_i,
  output logic            empty_o,
  output logic            full_o,
  output logic [PC_W-1:0] head_pc_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  tag_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CNT_W'(DEPTH));
  assign head_pc_o = tag_q[rp_q];
  assign do_push   = push_i && !full_o;
  assign do_pop    = done_i && !empty_o;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
    end else begin
      if (do_push) begin
        tag_q[wp_q] <= pc_i;
        wp_q        <= nxt(wp_q);
      end
      if (do_pop) rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/fault_arb.sv
`timescale 1ns/1ps
module fault_arb
  import acc_fault_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fetch_ev_i,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            rd_ev_i,
  input  logic            wr_ev_i,
  input  logic            wr_prot_i,
  input  logic [PC_W-1:0] cur_pc_i,
  input  logic [PC_W-1:0] store_pc_i,
  input  logic            ack_i,
  output logic            req_o,
  output logic [3:0]      fs_o,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] store_pc_o
);
  fs_e fs_q;

  assign fs_o = fs_q;

  // priority by age: write, then read, then fetch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o      <= 1'b0;
      fs_q       <= FS_FETCH;
      pc_o       <= '0;
      store_pc_o <= '0;
    end else if (req_o) begin
      if (ack_i) req_o <= 1'b0;
    end else if (wr_ev_i) begin
      req_o      <= 1'b1;
      fs_q       <= wr_prot_i ? FS_WPROT : FS_WRITE;
      pc_o       <= cur_pc_i;
      store_pc_o <= store_pc_i;
    end else if (rd_ev_i) begin
      req_o      <= 1'b1;
      fs_q       <= FS_READ;
      pc_o       <= cur_pc_i;
      store_pc_o <= '0;
    end else if (fetch_ev_i) begin
      req_o      <= 1'b1;
      fs_q       <= FS_FETCH;
      pc_o       <= fetch_pc_i;
      store_pc_o <= '0;
    end
  end
endmodule

// File: rtl/acc_fault_unit.sv
`timescale 1ns/1ps
module acc_fault_unit
  import acc_fault_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int TAKE_W   = 2,
  parameter int PF_DEPTH = 4,
  parameter int WB_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pf_valid_i,
  input  logic              pf_err_i,
  input  logic              flush_i,
  input  logic              issue_i,
  input  logic [TAKE_W-1:0] issue_words_i,
  input  logic [PC_W-1:0]   issue_pc_i,
  input  logic              nop_i,
  input  logic              rd_resp_i,
  input  logic              rd_err_i,
  input  logic              wr_push_i,
  input  logic [PC_W-1:0]   wr_pc_i,
  input  logic              wr_done_i,
  input  logic              wr_err_i,
  input  logic              wr_prot_i,
  input  logic              exc_ack_i,
  output logic              exc_req_o,
  output logic [3:0]        exc_fs_o,
  output logic [7:0]        exc_vec_o,
  output logic [PC_W-1:0]   exc_pc_o,
  output logic [PC_W-1:0]   exc_store_pc_o,
  output logic              kill_o,
  output logic              stall_o
);
  logic            pf_hit, fetch_ev, rd_ev, wr_ev;
  logic            wb_empty, wb_full;
  logic [PC_W-1:0] wb_head_pc, cur_pc_q;
  logic            nop_pend_q;

  pf_err_track #(.DEPTH(PF_DEPTH), .TAKE_W(TAKE_W)) u_pf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (pf_valid_i),
    .err_i   (pf_err_i),
    .flush_i (flush_i),
    .pop_i   (issue_i),
    .pop_n_i (issue_words_i),
    .hit_o   (pf_hit)
  );

  wr_buf_track #(.DEPTH(WB_DEPTH), .PC_W(PC_W)) u_wb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (wr_push_i),
    .pc_i      (wr_pc_i),
    .done_i    (wr_done_i),
    .empty_o   (wb_empty),
    .full_o    (wb_full),
    .head_pc_o (wb_head_pc)
  );

  assign fetch_ev = issue_i && pf_hit;
  assign rd_ev    = rd_resp_i && rd_err_i;
  assign wr_ev    = wr_done_i && wr_err_i && !wb_empty;

  fault_arb #(.PC_W(PC_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fetch_ev_i (fetch_ev),
    .fetch_pc_i (issue_pc_i),
    .rd_ev_i    (rd_ev),
    .wr_ev_i    (wr_ev),
    .wr_prot_i  (wr_prot_i),
    .cur_pc_i   (cur_pc_q),
    .store_pc_i (wb_head_pc),
    .ack_i      (exc_ack_i),
    .req_o      (exc_req_o),
    .fs_o       (exc_fs_o),
    .pc_o       (exc_pc_o),
    .store_pc_o (exc_store_pc_o)
  );

  assign exc_vec_o = exc_req_o ? ACC_VEC : 8'd0;
  assign kill_o    = fetch_ev || rd_ev;
  assign stall_o   = wb_full || (nop_pend_q && !wb_empty);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_pc_q   <= '0;
      nop_pend_q <= 1'b0;
    end else begin
      if (issue_i) cur_pc_q <= issue_pc_i;
      if (issue_i && nop_i) nop_pend_q <= 1'b1;
      else if (wb_empty)    nop_pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_fault_chk.sv
`timescale 1ns/1ps
module acc_fault_chk #(
  parameter int PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rd_resp_i,
  input logic            rd_err_i,
  input logic            wr_done_i,
  input logic            wr_err_i,
  input logic            exc_ack_i,
  input logic            exc_req_o,
  input logic [3:0]      exc_fs_o,
  input logic [7:0]      exc_vec_o,
  input logic [PC_W-1:0] exc_pc_o,
  input logic            kill_o
);
  AST_FS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> ((exc_fs_o == 4'b0100 || exc_fs_o == 4'b1000 ||
                    exc_fs_o == 4'b1001 || exc_fs_o == 4'b1100) && exc_vec_o == 8'd2)); // R1

  AST_KILL_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_o && !exc_req_o) |=> exc_req_o); // R4

  AST_READ_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_resp_i && rd_err_i && !exc_req_o && !(wr_done_i && wr_err_i))
      |=> (exc_req_o && exc_fs_o == 4'b1100)); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_o && !exc_ack_i) |=> (exc_req_o && $stable(exc_fs_o) && $stable(exc_pc_o))); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_req_o && exc_ack_i) |=> !exc_req_o); // R9
endmodule

bind acc_fault_unit acc_fault_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/acc_fault_unit_bench.sv
`timescale 1ns/1ps
module acc_fault_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pf_valid_i, pf_err_i, flush_i, issue_i, nop_i;
  logic [1:0]  issue_words_i;
  logic [31:0] issue_pc_i, wr_pc_i;
  logic        rd_resp_i, rd_err_i, wr_push_i, wr_done_i, wr_err_i, wr_prot_i, exc_ack_i;
  logic        exc_req_o, kill_o, stall_o;
  logic [3:0]  exc_fs_o;
  logic [7:0]  exc_vec_o;
  logic [31:0] exc_pc_o, exc_store_pc_o;

  int n_chk = 0;
  int n_err = 0;

  acc_fault_unit u_acc_fault_unit (.*);

  always #10 clk_i = ~clk_i;

  task automatic clr();
    pf_valid_i = 0; pf_err_i = 0; flush_i = 0; issue_i = 0; nop_i = 0;
    issue_words_i = 0; issue_pc_i = 0; wr_pc_i = 0;
    rd_resp_i = 0; rd_err_i = 0; wr_push_i = 0; wr_done_i = 0;
    wr_err_i = 0; wr_prot_i = 0; exc_ack_i = 0;
  endtask

  task automatic tick();
    @(posedge clk_i); #1 clr(); @(negedge clk_i);
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic ack();
    exc_ack_i = 1; tick();
    chk("R9 clear after ack", exc_req_o, 0);
  endtask

  task automatic push_pf(input logic e);
    pf_valid_i = 1; pf_err_i = e; tick();
  endtask

  task automatic issue_clean(input logic [31:0] pc, input logic nop);
    push_pf(0);
    issue_i = 1; issue_words_i = 1; issue_pc_i = pc; nop_i = nop; tick();
  endtask

  task automatic push_wr(input logic [31:0] pc);
    wr_push_i = 1; wr_pc_i = pc; tick();
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    clr();
    repeat (3) @(negedge clk_i);
    chk("R11 req", exc_req_o, 0);
    chk("R11 kill", kill_o, 0);
    chk("R11 stall", stall_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // fetch sweep: all error patterns over 3 words, every issue width
    for (int pat = 0; pat < 8; pat++) begin
      for (int n = 1; n <= 3; n++) begin
        logic e1, e2;
        logic [31:0] pc;
        pc = 32'h4000 + pat * 16 + n * 4;
        flush_i = 1; tick();
        for (int w = 0; w < 3; w++) push_pf(pat[w]);
        chk("R2 no request on arrival", exc_req_o, 0);
        e1 = |(pat[2:0] & 3'((1 << n) - 1));
        issue_i = 1; issue_words_i = 2'(n); issue_pc_i = pc;
        #1 chk("R4 kill on faulted issue", kill_o, e1);
        tick();
        chk("R2 request after issue", exc_req_o, e1);
        if (e1) begin
          chk("R2 fetch fs", exc_fs_o, 4'b0100);
          chk("R1 vector", exc_vec_o, 8'd2);
          chk("R2 fetch pc", exc_pc_o, pc);
          ack();
        end
        if (n < 3) begin
          e2 = |(3'(pat >> n));
          issue_i = 1; issue_words_i = 2'(3 - n); issue_pc_i = pc + 2;
          #1 chk("R4 kill on leftover issue", kill_o, e2);
          tick();
          chk("R2 leftover words", exc_req_o, e2);
          if (e2) begin
            chk("R2 leftover pc", exc_pc_o, pc + 2);
            ack();
          end
        end
      end
    end

    // flush drops a held prefetch error
    push_pf(1);
    flush_i = 1; tick();
    push_pf(0);
    issue_i = 1; issue_words_i = 1; issue_pc_i = 32'h500;
    #1 chk("R3 kill after flush", kill_o, 0);
    tick();
    chk("R3 no request after flush", exc_req_o, 0);

    // read errors
    issue_clean(32'h300, 0);
    rd_resp_i = 1;
    #1 chk("R4 no kill clean read", kill_o, 0);
    tick();
    chk("R5 clean read no request", exc_req_o, 0);
    rd_resp_i = 1; rd_err_i = 1;
    #1 chk("R4 kill on read error", kill_o, 1);
    tick();
    chk("R5 read request", exc_req_o, 1);
    chk("R5 read fs", exc_fs_o, 4'b1100);
    chk("R5 read pc", exc_pc_o, 32'h300);
    // R9: held while a write error comes in
    push_wr(32'h900);
    chk("R9 still held", exc_req_o, 1);
    wr_done_i = 1; wr_err_i = 1; tick();
    chk("R9 fs held", exc_fs_o, 4'b1100);
    chk("R9 pc held", exc_pc_o, 32'h300);
    ack();
    tick();
    chk("R9 dropped event stays dropped", exc_req_o, 0);

    // write sweep over fill level and protection flag
    for (int fill = 1; fill <= 4; fill++) begin
      for (int prot = 0; prot < 2; prot++) begin
        logic [31:0] cpc;
        cpc = 32'h2000 + fill * 8 + prot * 4;
        issue_clean(cpc, 0);
        for (int k = 0; k < fill; k++) push_wr(32'h1000 + k * 4);
        chk("R10 stall when full", stall_o, fill == 4);
        for (int k = 0; k < fill - 1; k++) begin
          wr_done_i = 1; tick();
        end
        chk("R6 clean completions no request", exc_req_o, 0);
        wr_done_i = 1; wr_err_i = 1; wr_prot_i = prot[0]; tick();
        chk("R6 write request", exc_req_o, 1);
        chk("R6 write fs", exc_fs_o, prot[0] ? 4'b1001 : 4'b1000);
        chk("R6 write pc", exc_pc_o, cpc);
        chk("R6 store tag", exc_store_pc_o, 32'h1000 + (fill - 1) * 4);
        chk("R10 stall off when drained", stall_o, 0);
        ack();
      end
    end

    // NOP drains write buffer
    issue_clean(32'h180, 0);
    push_wr(32'h100);
    push_wr(32'h104);
    issue_clean(32'h200, 1);
    chk("R7 stall after NOP", stall_o, 1);
    wr_done_i = 1; tick();
    chk("R7 stall while draining", stall_o, 1);
    wr_done_i = 1; wr_err_i = 1; tick();
    chk("R7 stall released", stall_o, 0);
    chk("R7 error on NOP", exc_req_o, 1);
    chk("R7 NOP pc", exc_pc_o, 32'h200);
    chk("R7 store tag", exc_store_pc_o, 32'h104);
    ack();
    issue_clean(32'h210, 1);
    chk("R7 no stall when empty", stall_o, 0);

    // priority
    issue_clean(32'h600, 0);
    push_wr(32'h700);
    push_pf(1);
    issue_i = 1; issue_words_i = 1; issue_pc_i = 32'h604;
    rd_resp_i = 1; rd_err_i = 1; wr_done_i = 1; wr_err_i = 1;
    tick();
    chk("R8 write wins", exc_fs_o, 4'b1000);
    chk("R8 write pc", exc_pc_o, 32'h600);
    ack();
    push_pf(1);
    issue_i = 1; issue_words_i = 1; issue_pc_i = 32'h608;
    rd_resp_i = 1; rd_err_i = 1;
    tick();
    chk("R8 read beats fetch", exc_fs_o, 4'b1100);
    chk("R8 read pc", exc_pc_o, 32'h604);
    ack();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule